// File: doc/BRIEF.md
# Comma-Locked 10-Bit Word Aligner

This block sits behind a serial receiver's clock recovery. The recovered stream reaches it as ten bits per clock, but the character boundary of the 8B/10B code can lie anywhere inside that word. The block looks for the comma, a seven-bit run that cannot occur anywhere else in valid 8B/10B data. It accepts the comma in either running-disparity polarity, and once it finds one it snaps the 10-bit boundary to the comma's first bit. Aligned characters then go on to an 8B/10B decoder.

Bits travel least significant first: vector bit 0 of an input word is the earliest bit on the line (8B/10B bit a), and bit 9 is the latest (bit j). Each cycle the block keeps the newest word and the word before it as a 20-bit span, and it tests all ten start positions of that span for a comma. After reset no boundary is trusted and the block is searching. The first comma sets the locked flag. Every comma found raises a one-cycle detect pulse in the same cycle as the comma character on the output.

Top module: `comma_word_aligner`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `char_o` = 0, `comma_det_o` = 0 and `locked_o` = 0.
- R2: A comma with line bits a..g = 0011111 (vector bits [6:0] = 7'b1111100) is detected.
- R3: A comma with line bits a..g = 1100000 (vector bits [6:0] = 7'b0000011) is detected.
- R4: A comma is found at any of the ten bit offsets within a word, including commas that straddle two input words.
- R5: A character whose first line bit is carried in the word sampled at clock edge n appears on `char_o` after edge n+2.
- R6: `comma_det_o` is high for exactly one cycle per comma found, in the same cycle as that comma character on `char_o`, and is low in every other cycle.
- R7: `locked_o` stays low until the first comma is found, goes high in the same cycle as that comma's `comma_det_o` pulse, and stays high until reset.
- R8: Until a comma is found, the character boundary does not change: after a bit slip, characters continue on the old boundary until a comma arrives.
- R9: A comma at a new offset moves the boundary, and from that comma onward characters are cut at the new offset.
- R10: When two commas start inside the same ten-offset search window, the one with the lower offset (earlier on the line) is taken.
- R11: Reset taken while locked returns the block to the searching, unlocked state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_word_i | input | 10 | Unaligned received bits, bit 0 earliest on the line |
| char_o | output | 10 | Aligned character, bit 0 = bit a |
| comma_det_o | output | 1 | One-cycle pulse with each comma character on `char_o` |
| locked_o | output | 1 | A comma has set the boundary since reset |

## Verification
Assertions check on every clock that the detect pulse never appears unlocked and that it always carries a comma pattern in the low seven bits of the output. They also check that the lock flag holds once set, that the boundary register moves only on a detected comma, and that the offset picker grants at most one offset and never a higher one than a matching lower offset. The bench alone can show that the right character comes out at the right latency for every starting offset, that both polarities are found, that characters stay on the old boundary after a bit slip, and that the earlier of two overlapping commas wins. It can also show that no pulse or lock ever appears on a stream that has no comma.

// File: rtl/cwa_pkg.sv
// Shared constants for the comma word aligner.
// Assumes the 8B/10B convention: vector bit 0 is the first bit on the line.
package cwa_pkg;

    // Width of one coded character and of one input word.
    localparam int unsigned CHAR_W  = 10;
    // Length of the comma run that identifies a character boundary.
    localparam int unsigned COMMA_W = 7;

    // Comma starting with two zeros on the line (line order 0011111).
    localparam logic [COMMA_W-1:0] COMMA_ZERO_LEAD = 7'b1111100;
    // Comma starting with two ones on the line (line order 1100000).
    localparam logic [COMMA_W-1:0] COMMA_ONE_LEAD  = 7'b0000011;

    // True when a seven-bit slice holds a comma of either polarity.
    function automatic logic is_comma(input logic [COMMA_W-1:0] slice);
        return (slice == COMMA_ZERO_LEAD) || (slice == COMMA_ONE_LEAD);
    endfunction

endpackage

// File: rtl/cwa_window.sv
// Two-word history register.
// Holds the newest word and the one before it. The older word sits in the
// low half so that bit order in the window follows line order.
// Assumes one input word per clock and no gaps.
module cwa_window #(
    parameter int unsigned W = cwa_pkg::CHAR_W,
    localparam int unsigned SPAN_W = 2 * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      word_i,
    output logic [SPAN_W-1:0] span_o
);

    logic [W-1:0] newest_q;
    logic [W-1:0] older_q;

    // Shift the incoming word through the two-deep history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            newest_q <= '0;
            older_q  <= '0;
        end else begin
            newest_q <= word_i;
            older_q  <= newest_q;
        end
    end

    assign span_o = {newest_q, older_q};

endmodule

// File: rtl/cwa_search.sv
// Comma search over every start offset of a character.
// Compares the seven-bit slice at each of the W start offsets against both
// comma polarities, then grants the lowest matching offset.
// Assumes the span holds line bits in order, earliest at bit 0.
module cwa_search #(
    parameter int unsigned W  = cwa_pkg::CHAR_W,
    parameter int unsigned CW = cwa_pkg::COMMA_W,
    localparam int unsigned SRCH_W = W + CW - 1,
    localparam int unsigned OFF_W  = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRCH_W-1:0] span_i,
    output logic              hit_o,
    output logic [OFF_W-1:0]  hit_off_o
);

    logic [W-1:0] zero_lead_m;
    logic [W-1:0] one_lead_m;
    logic [W-1:0] match;
    logic [W-1:0] grant;

    // One comparator pair per start offset.
    for (genvar k = 0; k < W; k++) begin : g_offset
        assign zero_lead_m[k] = (span_i[k +: CW] == cwa_pkg::COMMA_ZERO_LEAD);
        assign one_lead_m[k]  = (span_i[k +: CW] == cwa_pkg::COMMA_ONE_LEAD);
        assign match[k]       = zero_lead_m[k] | one_lead_m[k];
    end

    // Keep only the lowest set match bit: the earliest comma on the line.
    always_comb begin
        grant = match & (~match + W'(1));
    end

    // Encode the granted offset into a binary index.
    always_comb begin
        hit_off_o = '0;
        for (int k = 0; k < W; k++) begin
            if (grant[k]) begin
                hit_off_o = hit_off_o | OFF_W'(k);
            end
        end
    end

    assign hit_o = |match;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R10

    AST_GRANT_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit_o |-> ((grant != '0) && (((grant - W'(1)) & match) == '0))); // R10

endmodule

// File: rtl/cwa_align.sv
// Boundary register and character output stage.
// Moves the boundary to a newly found comma, otherwise keeps it, and cuts
// the aligned character out of the span. Raises the detect pulse and the
// lock flag together with the comma character.
// Assumes the search result refers to the same span given here.
module cwa_align #(
    parameter int unsigned W  = cwa_pkg::CHAR_W,
    parameter int unsigned CW = cwa_pkg::COMMA_W,
    localparam int unsigned SPAN_W = 2 * W,
    localparam int unsigned OFF_W  = $clog2(W),
    localparam int unsigned IDX_W  = $clog2(SPAN_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SPAN_W-1:0] span_i,
    input  logic              hit_i,
    input  logic [OFF_W-1:0]  hit_off_i,
    output logic [W-1:0]      char_o,
    output logic              det_o,
    output logic              locked_o
);

    logic [OFF_W-1:0] off_q;
    logic [OFF_W-1:0] sel_off;
    logic [IDX_W-1:0] sel_idx;
    logic [W-1:0]     char_d;

    // Choose the new offset on a find, else the held one.
    always_comb begin
        sel_off = hit_i ? hit_off_i : off_q;
        sel_idx = IDX_W'(sel_off);
        char_d  = span_i[sel_idx +: W];
    end

    // Hold or move the character boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
        end else if (hit_i) begin
            off_q <= hit_off_i;
        end
    end

    // Register the aligned character, the detect pulse and the lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_o   <= '0;
            det_o    <= 1'b0;
            locked_o <= 1'b0;
        end else begin
            char_o <= char_d;
            det_o  <= hit_i;
            if (hit_i) begin
                locked_o <= 1'b1;
            end
        end
    end

    AST_BOUNDARY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_i |=> $stable(off_q)); // R8

    AST_PULSE_CARRIES_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        det_o |-> cwa_pkg::is_comma(char_o[CW-1:0])); // R6

    AST_PULSE_NEEDS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        det_o |-> locked_o); // R7

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> locked_o); // R7

endmodule

// File: rtl/comma_word_aligner.sv
// Comma word aligner top.
// Takes unaligned 10-bit words, finds 8B/10B commas of either polarity at
// any offset, and emits aligned characters with a detect pulse and a lock
// flag. Latency from the word carrying a character's first bit to the
// output is two clocks. Assumes continuous input, one word per clock.
module comma_word_aligner #(
    parameter int unsigned W  = cwa_pkg::CHAR_W,
    parameter int unsigned CW = cwa_pkg::COMMA_W,
    localparam int unsigned SPAN_W = 2 * W,
    localparam int unsigned SRCH_W = W + CW - 1,
    localparam int unsigned OFF_W  = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rx_word_i,
    output logic [W-1:0] char_o,
    output logic         comma_det_o,
    output logic         locked_o
);

    logic [SPAN_W-1:0] span;
    logic              hit;
    logic [OFF_W-1:0]  hit_off;

    cwa_window #(.W(W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_i (rx_word_i),
        .span_o (span)
    );

    cwa_search #(.W(W), .CW(CW)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .span_i    (span[SRCH_W-1:0]),
        .hit_o     (hit),
        .hit_off_o (hit_off)
    );

    cwa_align #(.W(W), .CW(CW)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .span_i    (span),
        .hit_i     (hit),
        .hit_off_i (hit_off),
        .char_o    (char_o),
        .det_o     (comma_det_o),
        .locked_o  (locked_o)
    );

endmodule

// File: tb/tb_comma_word_aligner.sv
`timescale 1ns/1ps
module tb_comma_word_aligner;

    localparam logic [9:0] D_ALT  = 10'b0101010101; // alternating data char
    localparam logic [9:0] K_ZERO = 10'b0101111100; // line 0011111010
    localparam logic [9:0] K_ONE  = 10'b1010000011; // line 1100000101

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] rx_word = '0;
    logic [9:0] char_o;
    logic       comma_det_o;
    logic       locked_o;

    int checks = 0;
    int errors = 0;

    logic [1023:0] line_bits;
    int ptr;
    int cpos [0:63];
    int ncp;
    int cur_off;
    bit have_lock;
    bit was_locked = 1'b0;

    always #2.5 clk = ~clk;

    comma_word_aligner dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_word_i   (rx_word),
        .char_o      (char_o),
        .comma_det_o (comma_det_o),
        .locked_o    (locked_o)
    );

    task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic clear_stream();
        for (int i = 0; i < 1024; i++) line_bits[i] = (i % 2 == 0);
        ptr = 0;
        ncp = 0;
    endtask

    task automatic put_char(input logic [9:0] c, input bit is_k);
        if (is_k) begin
            cpos[ncp] = ptr;
            ncp++;
        end
        for (int i = 0; i < 10; i++) line_bits[ptr + i] = c[i];
        ptr += 10;
    endtask

    function automatic logic [9:0] word_at(input int n);
        return line_bits[10 * n +: 10];
    endfunction

    // Expected outputs at bench iteration n come from the word slot n-3.
    task automatic check_cycle(input int n, input string tag);
        int base;
        int found;
        string ctag;
        string dtag;
        base  = 10 * (n - 3);
        found = -1;
        for (int j = 0; j < ncp; j++) begin
            if (cpos[j] >= base && cpos[j] < base + 10 && (found < 0 || cpos[j] < found))
                found = cpos[j];
        end
        ctag = tag;
        if (found >= 0) begin
            if (!have_lock) ctag = "R5";
            else if (tag == "R10") ctag = "R10";
            else if (found - base != cur_off) ctag = "R9";
            else ctag = "R4";
            cur_off   = found - base;
            have_lock = 1'b1;
            dtag = (line_bits[found] == 1'b0) ? "R2" : "R3";
        end else begin
            dtag = "R6";
        end
        check(dtag, {9'd0, comma_det_o}, {9'd0, found >= 0});
        check("R7", {9'd0, locked_o}, {9'd0, have_lock});
        if (have_lock) check(ctag, char_o, line_bits[base + cur_off +: 10]);
    endtask

    task automatic run_stream(input int nwords, input string tag);
        rst_n   = 1'b0;
        rx_word = '0;
        repeat (3) @(negedge clk);
        // R1 reset state; R11 when the previous run had locked
        check(was_locked ? "R11" : "R1", {char_o[9:0]}, 10'd0);
        check(was_locked ? "R11" : "R1", {8'd0, comma_det_o, locked_o}, 10'd0);
        have_lock = 1'b0;
        cur_off   = 0;
        for (int n = 0; n < nwords + 3; n++) begin
            @(negedge clk);
            if (n == 0) rst_n = 1'b1;
            if (n >= 3) check_cycle(n, tag);
            rx_word = word_at(n);
        end
        was_locked = locked_o;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R7: a stream with no comma never locks or pulses
        clear_stream();
        for (int i = 0; i < 20; i++) put_char(D_ALT, 1'b0);
        run_stream(22, "R7");

        // R2 R3 R4 R5 R6: both polarities at every starting offset
        for (int s = 0; s < 10; s++) begin
            clear_stream();
            ptr = s;
            for (int i = 0; i < 3; i++) put_char(D_ALT, 1'b0);
            put_char(K_ZERO, 1'b1);
            for (int i = 0; i < 4; i++) put_char(D_ALT, 1'b0);
            put_char(K_ONE, 1'b1);
            for (int i = 0; i < 3; i++) put_char(D_ALT, 1'b0);
            put_char(K_ZERO, 1'b1);
            put_char(K_ONE, 1'b1);
            for (int i = 0; i < 3; i++) put_char(D_ALT, 1'b0);
            run_stream(20, "R4");
        end

        // R8 R9: bit slip of every size, held boundary then realignment
        for (int s = 0; s < 10; s++) begin
            for (int d = 1; d < 10; d++) begin
                clear_stream();
                ptr = s;
                for (int i = 0; i < 2; i++) put_char(D_ALT, 1'b0);
                put_char(K_ZERO, 1'b1);
                for (int i = 0; i < 2; i++) put_char(D_ALT, 1'b0);
                ptr += d;
                for (int i = 0; i < 3; i++) put_char(D_ALT, 1'b0);
                put_char((d % 2 == 0) ? K_ONE : K_ZERO, 1'b1);
                for (int i = 0; i < 3; i++) put_char(D_ALT, 1'b0);
                run_stream(16, "R8");
            end
        end

        // R10: two overlapping commas, the earlier one wins its window
        for (int s = 0; s < 10; s++) begin
            clear_stream();
            ptr = 20 + s;
            cpos[0] = ptr;
            cpos[1] = ptr + 5;
            ncp = 2;
            for (int i = 0; i < 12; i++) line_bits[ptr + i] = (i >= 2 && i <= 6);
            ptr += 12;
            ptr += 10;
            put_char(K_ZERO, 1'b1);
            for (int i = 0; i < 3; i++) put_char(D_ALT, 1'b0);
            run_stream(12, "R10");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule